// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch is taken. A three-bit condition code picks one test out of eight, and the test is applied to a 32-bit word presented on the shared data bus. The block can return a constant false or a constant true. It can also test the word for zero, for non-zero, or check its sign. When the load strobe is high, the chosen outcome is written into a one-bit flag register. The sequencer reads that flag in a later step to decide whether the program counter is rewritten.

The condition code goes through a one-hot decoder. Each decoder line gates one precomputed test result, and the gated results are ORed into the next value of the flag. The sign tests look only at the most significant bit of the word, so a word of zero counts as positive. Codes 6 and 7 are reserved and always produce false.

Top module: `brcond_eval`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and until a load has been accepted after its release, `cond_flag` reads 0.
- R2: For every condition code value, exactly one internal decoder select line is high.
- R3: A load with code 0 (never) sets `cond_flag` to 0 on the next rising edge, whatever the bus word.
- R4: A load with code 1 (always) sets `cond_flag` to 1 on the next rising edge, whatever the bus word.
- R5: A load with code 2 sets `cond_flag` to 1 exactly when all 32 bus bits are 0.
- R6: A load with code 3 sets `cond_flag` to 1 exactly when at least one bus bit is 1.
- R7: A load with code 4 sets `cond_flag` to 1 exactly when bus bit 31 is 0. A zero word therefore counts as positive.
- R8: A load with code 5 sets `cond_flag` to 1 exactly when bus bit 31 is 1.
- R9: A load with code 6 or code 7 sets `cond_flag` to 0.
- R10: While `load_cond` is low, `cond_flag` keeps its value across edges, whatever the code and the bus word.
- R11: Reset takes priority over a load in the same cycle. Loads are ignored for two rising edges after reset is released, while the synchronized reset is still active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_word | input | 32 | Word on the shared bus to be tested |
| cond_code | input | 3 | Selects the branch condition |
| load_cond | input | 1 | Strobe that captures the selected outcome into the flag |
| cond_flag | output | 1 | Registered branch-taken flag |

## Verification
A load strobe and a reset can arrive in the same cycle, and so can a load and the end of reset. The bench first sets the flag to 1. It then pulls `rst_n` low while a load with code 1 is active, and expects the flag to fall at once and stay 0. It releases reset while the strobe is still asserted and expects the flag to stay 0 for the two synchronizer edges. After those two edges, a load must take effect again.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int CODE_W  = 3;
  localparam int NCODES  = 1 << CODE_W;
  localparam int WORD_W  = 32;

  typedef enum logic [CODE_W-1:0] {
    CC_NEVER   = 3'd0,
    CC_ALWAYS  = 3'd1,
    CC_ZERO    = 3'd2,
    CC_NONZERO = 3'd3,
    CC_POS     = 3'd4,
    CC_NEG     = 3'd5,
    CC_RSV6    = 3'd6,
    CC_RSV7    = 3'd7
  } cc_e;
endpackage

// File: rtl/brc_rst_sync.sv
module brc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/brc_code_decoder.sv
module brc_code_decoder #(
  parameter int CODE_W = 3,
  localparam int NSEL  = 1 << CODE_W
) (
  input  logic [CODE_W-1:0] code,
  output logic [NSEL-1:0]   sel
);
  for (genvar i = 0; i < NSEL; i++) begin : g_line
    assign sel[i] = (code == CODE_W'(i));
  end
endmodule

// File: rtl/brc_word_tests.sv
module brc_word_tests #(
  parameter int WORD_W = 32,
  localparam int SIGN_BIT = WORD_W - 1
) (
  input  logic [WORD_W-1:0] word,
  output logic              is_zero,
  output logic              is_neg
);
  assign is_zero = ~|word;
  assign is_neg  = word[SIGN_BIT];
endmodule

// File: rtl/brc_flag_reg.sv
module brc_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic d,
  output logic q
);
  logic q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/brcond_eval.sv
module brcond_eval
  import brc_pkg::*;
#(
  parameter int W      = WORD_W,
  parameter int CW     = CODE_W,
  parameter int SYNC_N = 2,
  localparam int NSEL  = 1 << CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  bus_word,
  input  logic [CW-1:0] cond_code,
  input  logic          load_cond,
  output logic          cond_flag
);
  logic            rst_int_n;
  logic [NSEL-1:0] sel;
  logic [NSEL-1:0] outcome;
  logic            w_zero;
  logic            w_neg;
  logic            take_nxt;

  brc_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_int_n)
  );

  brc_code_decoder #(.CODE_W(CW)) u_dec (
    .code(cond_code), .sel(sel)
  );

  brc_word_tests #(.WORD_W(W)) u_tst (
    .word(bus_word), .is_zero(w_zero), .is_neg(w_neg)
  );

  // One result per condition code; reserved codes stay 0.
  always_comb begin
    outcome = '0;
    outcome[int'(CC_ALWAYS)]  = 1'b1;
    outcome[int'(CC_ZERO)]    = w_zero;
    outcome[int'(CC_NONZERO)] = ~w_zero;
    outcome[int'(CC_POS)]     = ~w_neg;
    outcome[int'(CC_NEG)]     = w_neg;
  end

  assign take_nxt = |(outcome & sel);

  brc_flag_reg u_flag (
    .clk(clk), .rst_n(rst_int_n), .en(load_cond), .d(take_nxt), .q(cond_flag)
  );

  assert_onehot_sel_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot(sel));

  assert_never_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (load_cond && cond_code == CC_NEVER) |=> !cond_flag);

  assert_always_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (load_cond && cond_code == CC_ALWAYS) |=> cond_flag);

  assert_zero_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (load_cond && cond_code == CC_ZERO) |=> (cond_flag == ($past(bus_word) == '0)));

  assert_sign_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (load_cond && cond_code == CC_NEG) |=> (cond_flag == $past(bus_word[W-1])));

  assert_reserved_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (load_cond && cond_code[CW-1] && cond_code[CW-2]) |=> !cond_flag);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !load_cond |=> $stable(cond_flag));
endmodule

// File: tb/brcond_eval_bench.sv
module brcond_eval_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] bus_word;
  logic [2:0]  cond_code;
  logic        load_cond;
  logic        cond_flag;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  brcond_eval u_brcond_eval (
    .clk(clk), .rst_n(rst_n), .bus_word(bus_word),
    .cond_code(cond_code), .load_cond(load_cond), .cond_flag(cond_flag)
  );

  function automatic logic model(input logic [2:0] c, input logic [31:0] w);
    case (c)
      3'd1:    return 1'b1;
      3'd2:    return (w == 32'd0);
      3'd3:    return (w != 32'd0);
      3'd4:    return ~w[31];
      3'd5:    return w[31];
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic exp);
    n_vec++;
    if (cond_flag !== exp) begin
      n_bad++;
      $display("FAIL %s: cond_flag=%b expected=%b", req, cond_flag, exp);
    end
  endtask

  // Loads one code and word, then samples at the following falling edge.
  task automatic load_and_check(input string req, input logic [2:0] c, input logic [31:0] w);
    @(negedge clk);
    cond_code = c; bus_word = w; load_cond = 1'b1;
    @(negedge clk);
    load_cond = 1'b0;
    check(req, model(c, w));
  endtask

  task automatic t_reset_R1;
    rst_n = 1'b0; load_cond = 1'b0; cond_code = 3'd1; bus_word = '0;
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
  endtask

  task automatic t_never_R3;
    load_and_check("R4", 3'd1, 32'h0);
    load_and_check("R3", 3'd0, 32'hFFFF_FFFF);
    load_and_check("R4", 3'd1, 32'h8000_0000);
    load_and_check("R3", 3'd0, 32'h0);
  endtask

  task automatic t_zero_R5;
    load_and_check("R5", 3'd2, 32'h0);
    load_and_check("R5", 3'd2, 32'h0000_0001);
    load_and_check("R5", 3'd2, 32'h8000_0000);
    load_and_check("R5", 3'd2, 32'h0);
  endtask

  task automatic t_nonzero_R6;
    load_and_check("R6", 3'd3, 32'h0);
    load_and_check("R6", 3'd3, 32'h0001_0000);
    load_and_check("R6", 3'd3, 32'h8000_0000);
  endtask

  task automatic t_sign_R7_R8;
    load_and_check("R7", 3'd4, 32'h0);
    load_and_check("R7", 3'd4, 32'h8000_0000);
    load_and_check("R7", 3'd4, 32'h7FFF_FFFF);
    load_and_check("R8", 3'd5, 32'h8000_0000);
    load_and_check("R8", 3'd5, 32'h0);
    load_and_check("R8", 3'd5, 32'hFFFF_FFFF);
  endtask

  task automatic t_reserved_R9;
    load_and_check("R4", 3'd1, 32'h0);
    load_and_check("R9", 3'd6, 32'hFFFF_FFFF);
    load_and_check("R4", 3'd1, 32'h0);
    load_and_check("R9", 3'd7, 32'h0);
  endtask

  task automatic t_hold_R10;
    load_and_check("R4", 3'd1, 32'h0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      cond_code = 3'(i); bus_word = {i[3:0], 28'h0};
      @(negedge clk);
      check("R10", 1'b1);
    end
    load_and_check("R3", 3'd0, 32'h0);
    @(negedge clk);
    cond_code = 3'd1; bus_word = 32'h1;
    repeat (3) @(negedge clk);
    check("R10", 1'b0);
  endtask

  task automatic t_reset_vs_load_R11;
    load_and_check("R4", 3'd1, 32'h0);
    @(negedge clk);
    cond_code = 3'd1; load_cond = 1'b1; rst_n = 1'b0;
    #1 check("R11", 1'b0);
    @(negedge clk);
    check("R11", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", 1'b0);
    @(negedge clk);
    check("R11", 1'b0);
    @(negedge clk);
    check("R11", 1'b1);
    load_cond = 1'b0;
  endtask

  initial begin
    t_reset_R1();
    t_never_R3();
    t_zero_R5();
    t_nonzero_R6();
    t_sign_R7_R8();
    t_reserved_R9();
    t_hold_R10();
    t_reset_vs_load_R11();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1'b1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule